// File: doc/BRIEF.md
# Plug-in Slot Address Router

This block sits between a host-side access port and four plug-in module slots. Every host access names one of three local windows and carries an address, an 8- or 16-bit size and, for writes, the data. The router picks the target slot and a sub-space. It also trims the address to that sub-space's offset width and issues a one-cycle request strobe to the chosen slot.

Read data from the slot is captured one cycle after the strobe and returned with a single-cycle valid. An access that reaches no slot still completes: the slot may be absent or the sub-space unused. Such a read returns zero and such a write is dropped.

Each window can run big-endian. In that mode an 8-bit access has its byte-lane address bit flipped, and a 16-bit access has its data bytes exchanged on both the write and the read path. Three endianness bits live in a small byte-addressed configuration space. The first bit is not used for routing and is exported for the neighbouring carrier register window. Reads of the interrupt sub-space at offsets 0 and 2 also raise an acknowledge pulse that carries the slot and line number for the interrupt controller.

Top module: `modslot_router`

## Requirements
- R1: In the slot-space window (reqWin 0), the slot is address bits 9:8 and the sub-space field is bits 7:6. Field 0 is I/O (space code 0, offset = address & 0x7F). Field 2 is ID (code 2, offset = address & 0x3F). Field 3 is interrupt (code 3, offset = address & 0x3F). Field 1 issues no strobe, and a read of it returns 0.
- R2: In the 16-bit memory window (reqWin 1), the slot is address bits 24:23, the offset is address bits 22:0 and the space code is 4.
- R3: In the 8-bit memory window (reqWin 2), the slot is address bits 23:22, the offset is address bits 21:0 and the space code is 5. This window never applies address or data conversion.
- R4: When the endianness bit of window 0 or window 1 is set, an 8-bit access in that window has address bit 0 inverted before decoding, and its data passes unchanged.
- R5: When the endianness bit of window 0 or window 1 is set, a 16-bit access in that window has its write data bytes swapped toward the slot and its read data bytes swapped toward the host. The address is not altered.
- R6: A configuration write to byte 0x2B, 0x2F or 0x33 stores data bit 0 into endianness bit 0, 1 or 2. Bit 0 drives regBigEndian, bit 1 governs window 0 and bit 2 governs window 1. Reading one of these bytes returns the stored bit in bit 0 with all other bits 0. Any other byte reads 0, and writes to it change nothing.
- R7: An access whose slot's slotPresent bit is 0 issues no strobe. A read of such a slot returns data 0, and a write to it is discarded.
- R8: A routed access strobes exactly one slot, for one cycle, in the cycle after the request. Every read, routed or not, gives rspValid for one cycle two cycles after the request. Window id 3 is never routed.
- R9: A routed read of the interrupt sub-space at offset 0 or 2 pulses ackPulse together with the strobe. ackSlot gives the slot and ackLine is offset bit 1. Writes and other offsets give no pulse.
- R10: After reset, no strobe, response or acknowledge is active, and all three endianness bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrite | input | 1 | Configuration byte write strobe |
| cfgAddr | input | 8 | Configuration byte address |
| cfgWdata | input | 8 | Configuration write data |
| cfgRdata | output | 8 | Configuration read data for cfgAddr |
| regBigEndian | output | 1 | Endianness bit 0, for the carrier register window |
| slotPresent | input | 4 | One bit per slot, 1 when a module is fitted |
| reqValid | input | 1 | Host request valid, one cycle per access |
| reqWin | input | 2 | Window: 0 slot spaces, 1 16-bit memory, 2 8-bit memory |
| reqAddr | input | 25 | Byte address within the window |
| reqSize16 | input | 1 | 1 for 16-bit access, 0 for 8-bit |
| reqWrite | input | 1 | 1 for write |
| reqWdata | input | 16 | Host write data |
| dnStrobe | output | 4 | One-hot slot request strobe |
| dnWrite | output | 1 | Downstream direction |
| dnSize16 | output | 1 | Downstream access size |
| dnSpace | output | 3 | Space code (0 I/O, 2 ID, 3 interrupt, 4 memory16, 5 memory8) |
| dnOffset | output | 23 | Offset within the space |
| dnWdata | output | 16 | Write data after endian fixup |
| dnRdata | input | 16 | Read data from the strobed slot, valid in the strobe cycle |
| rspValid | output | 1 | Read response valid |
| rspData | output | 16 | Read response data |
| ackPulse | output | 1 | Interrupt acknowledge pulse |
| ackSlot | output | 2 | Slot of the acknowledge |
| ackLine | output | 1 | Interrupt line of the acknowledge |

## Verification
On every cycle the assertions check the strobe and response timing: the strobe is one-hot and follows a request, and each response follows a read two cycles earlier. They also check that a strobe never goes to an empty slot, that offsets stay within their sub-space width, and that every acknowledge travels with a read strobe of the interrupt space. The bench scenarios are needed for the decode itself: which slot, offset and space code each address produces. They are also needed for the byte swap and lane flip under each window's own endianness bit, and for the zero returned by empty or unused targets. The configuration bytes, with their single stored bit, are shown by the scenarios as well.

// File: rtl/modslot_pkg.sv
package modslot_pkg;
  localparam int ADDR_W = 25;
  localparam int DATA_W = 16;
  localparam int SLOT_W = 2;
  localparam int N_SLOTS = 1 << SLOT_W;
  localparam int N_ENDIAN = 3;
  localparam int SPACE_FIELD_W = 2;
  localparam int CTL_SPACE_LSB = 6;
  localparam int CTL_SLOT_LSB = CTL_SPACE_LSB + SPACE_FIELD_W;
  localparam int IO_OFF_W = 7;
  localparam int IDINT_OFF_W = 6;
  localparam int M16_OFF_W = 23;
  localparam int M8_OFF_W = 22;
  localparam int OFF_W = M16_OFF_W;

  typedef enum logic [2:0] {
    SP_IO    = 3'd0,
    SP_RSVD  = 3'd1,
    SP_ID    = 3'd2,
    SP_INT   = 3'd3,
    SP_MEM16 = 3'd4,
    SP_MEM8  = 3'd5
  } space_e;

  typedef enum logic [1:0] {
    WIN_SLOT  = 2'd0,
    WIN_MEM16 = 2'd1,
    WIN_MEM8  = 2'd2,
    WIN_NONE  = 2'd3
  } win_e;

  typedef struct packed {
    logic              fire;
    logic              write;
    logic              size16;
    logic [SLOT_W-1:0] slot;
    space_e            space;
    logic [OFF_W-1:0]  offset;
    logic              swapData;
    logic              emptyRead;
    logic              ack;
    logic              ackLine;
  } route_s;

  function automatic logic [DATA_W-1:0] swapBytes(input logic [DATA_W-1:0] d);
    return {d[DATA_W/2-1:0], d[DATA_W-1:DATA_W/2]};
  endfunction
endpackage

// File: rtl/modslot_ctrl.sv
module modslot_ctrl
  import modslot_pkg::*;
#(
  parameter logic [7:0] CFG_END_BASE   = 8'h2B,
  parameter logic [7:0] CFG_END_STRIDE = 8'd4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrite,
  input  logic [7:0]        cfgAddr,
  input  logic [7:0]        cfgWdata,
  output logic [7:0]        cfgRdata,
  output logic              regBigEndian,
  input  logic [N_SLOTS-1:0] slotPresent,
  input  logic              reqValid,
  input  logic [1:0]        reqWin,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqSize16,
  input  logic              reqWrite,
  output route_s            route
);
  logic [N_ENDIAN-1:0] bigEnd;
  logic [N_ENDIAN-1:0] cfgHit;

  // one stored bit per configuration byte, bytes spaced by the stride
  for (genvar g = 0; g < N_ENDIAN; g++) begin : g_endian
    localparam logic [7:0] BYTE_ADDR = CFG_END_BASE + 8'(g) * CFG_END_STRIDE;
    assign cfgHit[g] = (cfgAddr == BYTE_ADDR);
    always_ff @(posedge clk) begin
      if (!rstN) bigEnd[g] <= 1'b0;
      else if (cfgWrite && cfgHit[g]) bigEnd[g] <= cfgWdata[0];
    end
  end

  assign cfgRdata = {7'd0, |(cfgHit & bigEnd)};
  assign regBigEndian = bigEnd[0];

  win_e                      winSel;
  logic                      beSel;
  logic [ADDR_W-1:0]         effAddr;
  logic [SPACE_FIELD_W-1:0]  spField;
  logic [SLOT_W-1:0]         slot;
  space_e                    space;
  logic [OFF_W-1:0]          offset;
  logic                      usable;
  logic                      present;

  always_comb begin
    winSel = win_e'(reqWin);
    case (winSel)
      WIN_SLOT:  beSel = bigEnd[1];
      WIN_MEM16: beSel = bigEnd[2];
      default:   beSel = 1'b0;
    endcase
    effAddr = reqAddr ^ {{(ADDR_W-1){1'b0}}, beSel & ~reqSize16};
    spField = effAddr[CTL_SPACE_LSB +: SPACE_FIELD_W];
    slot    = '0;
    space   = SP_RSVD;
    offset  = '0;
    usable  = 1'b0;
    case (winSel)
      WIN_SLOT: begin
        slot   = effAddr[CTL_SLOT_LSB +: SLOT_W];
        space  = space_e'({1'b0, spField});
        usable = (space != SP_RSVD);
        if (space == SP_IO) offset = OFF_W'(effAddr[IO_OFF_W-1:0]);
        else                offset = OFF_W'(effAddr[IDINT_OFF_W-1:0]);
      end
      WIN_MEM16: begin
        slot   = effAddr[M16_OFF_W +: SLOT_W];
        space  = SP_MEM16;
        offset = OFF_W'(effAddr[M16_OFF_W-1:0]);
        usable = 1'b1;
      end
      WIN_MEM8: begin
        slot   = effAddr[M8_OFF_W +: SLOT_W];
        space  = SP_MEM8;
        offset = OFF_W'(effAddr[M8_OFF_W-1:0]);
        usable = 1'b1;
      end
      default: usable = 1'b0;
    endcase
    present = slotPresent[slot];

    route.fire      = reqValid & usable & present;
    route.write     = reqWrite;
    route.size16    = reqSize16;
    route.slot      = slot;
    route.space     = space;
    route.offset    = offset;
    route.swapData  = beSel & reqSize16;
    route.emptyRead = reqValid & ~reqWrite & ~(usable & present);
    route.ack       = reqValid & usable & present & ~reqWrite & (space == SP_INT)
                      & (offset[IDINT_OFF_W-1:2] == '0) & ~offset[0];
    route.ackLine   = offset[1];
  end
endmodule

// File: rtl/modslot_dpath.sv
module modslot_dpath
  import modslot_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  route_s             route,
  input  logic [DATA_W-1:0]  reqWdata,
  input  logic [DATA_W-1:0]  dnRdata,
  output logic [N_SLOTS-1:0] dnStrobe,
  output logic               dnWrite,
  output logic               dnSize16,
  output logic [2:0]         dnSpace,
  output logic [OFF_W-1:0]   dnOffset,
  output logic [DATA_W-1:0]  dnWdata,
  output logic               rspValid,
  output logic [DATA_W-1:0]  rspData,
  output logic               ackPulse,
  output logic [SLOT_W-1:0]  ackSlot,
  output logic               ackLine
);
  logic pendRead, pendEmpty, pendSwap;

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_strobe
    always_ff @(posedge clk) begin
      if (!rstN) dnStrobe[g] <= 1'b0;
      else       dnStrobe[g] <= route.fire && (route.slot == SLOT_W'(g));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dnWrite   <= 1'b0;
      dnSize16  <= 1'b0;
      dnSpace   <= 3'd0;
      dnOffset  <= '0;
      dnWdata   <= '0;
      ackPulse  <= 1'b0;
      ackSlot   <= '0;
      ackLine   <= 1'b0;
      pendRead  <= 1'b0;
      pendEmpty <= 1'b0;
      pendSwap  <= 1'b0;
      rspValid  <= 1'b0;
      rspData   <= '0;
    end else begin
      if (route.fire) begin
        dnWrite  <= route.write;
        dnSize16 <= route.size16;
        dnSpace  <= route.space;
        dnOffset <= route.offset;
        dnWdata  <= route.swapData ? swapBytes(reqWdata) : reqWdata;
      end
      ackPulse <= route.ack;
      if (route.ack) begin
        ackSlot <= route.slot;
        ackLine <= route.ackLine;
      end
      pendRead  <= (route.fire & ~route.write) | route.emptyRead;
      pendEmpty <= route.emptyRead;
      pendSwap  <= route.fire & route.swapData;
      rspValid  <= pendRead;
      if (pendRead) begin
        if (pendEmpty)     rspData <= '0;
        else if (pendSwap) rspData <= swapBytes(dnRdata);
        else               rspData <= dnRdata;
      end
    end
  end
endmodule

// File: rtl/modslot_router.sv
module modslot_router
  import modslot_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrite,
  input  logic [7:0]         cfgAddr,
  input  logic [7:0]         cfgWdata,
  output logic [7:0]         cfgRdata,
  output logic               regBigEndian,
  input  logic [N_SLOTS-1:0] slotPresent,
  input  logic               reqValid,
  input  logic [1:0]         reqWin,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               reqSize16,
  input  logic               reqWrite,
  input  logic [DATA_W-1:0]  reqWdata,
  output logic [N_SLOTS-1:0] dnStrobe,
  output logic               dnWrite,
  output logic               dnSize16,
  output logic [2:0]         dnSpace,
  output logic [OFF_W-1:0]   dnOffset,
  output logic [DATA_W-1:0]  dnWdata,
  input  logic [DATA_W-1:0]  dnRdata,
  output logic               rspValid,
  output logic [DATA_W-1:0]  rspData,
  output logic               ackPulse,
  output logic [SLOT_W-1:0]  ackSlot,
  output logic               ackLine
);
  route_s route;

  modslot_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWrite(cfgWrite), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .regBigEndian(regBigEndian),
    .slotPresent(slotPresent), .reqValid(reqValid), .reqWin(reqWin),
    .reqAddr(reqAddr), .reqSize16(reqSize16), .reqWrite(reqWrite),
    .route(route)
  );

  modslot_dpath u_dpath (
    .clk(clk), .rstN(rstN), .route(route),
    .reqWdata(reqWdata), .dnRdata(dnRdata),
    .dnStrobe(dnStrobe), .dnWrite(dnWrite), .dnSize16(dnSize16),
    .dnSpace(dnSpace), .dnOffset(dnOffset), .dnWdata(dnWdata),
    .rspValid(rspValid), .rspData(rspData),
    .ackPulse(ackPulse), .ackSlot(ackSlot), .ackLine(ackLine)
  );
endmodule

// File: rtl/modslot_router_chk.sv
module modslot_router_chk
  import modslot_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [N_SLOTS-1:0] slotPresent,
  input logic               reqValid,
  input logic               reqWrite,
  input logic [N_SLOTS-1:0] dnStrobe,
  input logic               dnWrite,
  input logic [2:0]         dnSpace,
  input logic [OFF_W-1:0]   dnOffset,
  input logic               rspValid,
  input logic               ackPulse,
  input logic [SLOT_W-1:0]  ackSlot
);
  // R8
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(dnStrobe));
  // R8
  strobe_after_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|dnStrobe) |-> $past(reqValid));
  // R8
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && !reqWrite, 2));
  // R7
  strobe_present_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|dnStrobe) |-> (|(dnStrobe & $past(slotPresent))));
  // R9
  ack_with_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> (dnStrobe[ackSlot] && !dnWrite && dnSpace == 3'd3));
  // R3
  mem8_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|dnStrobe) && dnSpace == 3'd5) |-> (dnOffset[OFF_W-1:M8_OFF_W] == '0));
  // R1
  io_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|dnStrobe) && dnSpace == 3'd0) |-> (dnOffset[OFF_W-1:IO_OFF_W] == '0));
  // R1
  idint_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|dnStrobe) && (dnSpace == 3'd2 || dnSpace == 3'd3))
      |-> (dnOffset[OFF_W-1:IDINT_OFF_W] == '0));
endmodule

bind modslot_router modslot_router_chk u_chk (
  .clk(clk), .rstN(rstN), .slotPresent(slotPresent), .reqValid(reqValid),
  .reqWrite(reqWrite), .dnStrobe(dnStrobe), .dnWrite(dnWrite),
  .dnSpace(dnSpace), .dnOffset(dnOffset), .rspValid(rspValid),
  .ackPulse(ackPulse), .ackSlot(ackSlot)
);

// File: tb/modslot_router_tb.sv
module modslot_router_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrite = 1'b0;
  logic [7:0]  cfgAddr = 8'd0;
  logic [7:0]  cfgWdata = 8'd0;
  logic [7:0]  cfgRdata;
  logic        regBigEndian;
  logic [3:0]  slotPresent = 4'hF;
  logic        reqValid = 1'b0;
  logic [1:0]  reqWin = 2'd0;
  logic [24:0] reqAddr = '0;
  logic        reqSize16 = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqWdata = '0;
  logic [3:0]  dnStrobe;
  logic        dnWrite, dnSize16;
  logic [2:0]  dnSpace;
  logic [22:0] dnOffset;
  logic [15:0] dnWdata;
  logic [15:0] dnRdata = '0;
  logic        rspValid;
  logic [15:0] rspData;
  logic        ackPulse;
  logic [1:0]  ackSlot;
  logic        ackLine;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  modslot_router u_dut (.*);

  typedef struct packed {
    logic [3:0]  rq;
    logic [1:0]  win;
    logic [24:0] addr;
    logic        sz16;
    logic        wr;
    logic [15:0] wdata;
    logic [2:0]  be;
    logic [3:0]  present;
    logic [15:0] mrd;
    logic [3:0]  expStb;
    logic [2:0]  expSp;
    logic [22:0] expOff;
    logic [15:0] expWd;
    logic        expRspV;
    logic [15:0] expRsp;
    logic        expAck;
    logic        expAckLine;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    // R1 I/O read, slot 1
    '{4'd1, 2'd0, 25'h125, 1'b0, 1'b0, 16'h0, 3'b000, 4'hF, 16'h00AB, 4'b0010, 3'd0, 23'h25, 16'h0, 1'b1, 16'h00AB, 1'b0, 1'b0},
    // R1 ID write, slot 2
    '{4'd1, 2'd0, 25'h2BF, 1'b1, 1'b1, 16'h1234, 3'b000, 4'hF, 16'h0, 4'b0100, 3'd2, 23'h3F, 16'h1234, 1'b0, 16'h0, 1'b0, 1'b0},
    // R1 interrupt space, offset 8: no acknowledge
    '{4'd1, 2'd0, 25'h3C8, 1'b1, 1'b0, 16'h0, 3'b000, 4'hF, 16'h5566, 4'b1000, 3'd3, 23'h08, 16'h0, 1'b1, 16'h5566, 1'b0, 1'b0},
    // R9 acknowledge line 0, slot 0
    '{4'd9, 2'd0, 25'h0C0, 1'b0, 1'b0, 16'h0, 3'b000, 4'hF, 16'h0011, 4'b0001, 3'd3, 23'h0, 16'h0, 1'b1, 16'h0011, 1'b1, 1'b0},
    // R9 acknowledge line 1, slot 2
    '{4'd9, 2'd0, 25'h2C2, 1'b0, 1'b0, 16'h0, 3'b000, 4'hF, 16'h0022, 4'b0100, 3'd3, 23'h2, 16'h0, 1'b1, 16'h0022, 1'b1, 1'b1},
    // R9 write to offset 0: no acknowledge
    '{4'd9, 2'd0, 25'h0C0, 1'b0, 1'b1, 16'h00FF, 3'b000, 4'hF, 16'h0, 4'b0001, 3'd3, 23'h0, 16'h00FF, 1'b0, 16'h0, 1'b0, 1'b0},
    // R1 unused sub-space field 1
    '{4'd1, 2'd0, 25'h140, 1'b0, 1'b0, 16'h0, 3'b000, 4'hF, 16'h7777, 4'b0000, 3'd0, 23'h0, 16'h0, 1'b1, 16'h0, 1'b0, 1'b0},
    // R2 16-bit memory window read, slot 2
    '{4'd2, 2'd1, 25'h1012345, 1'b1, 1'b0, 16'h0, 3'b000, 4'hF, 16'hBEEF, 4'b0100, 3'd4, 23'h012345, 16'h0, 1'b1, 16'hBEEF, 1'b0, 1'b0},
    // R3 8-bit memory window write, all endian bits set, no conversion
    '{4'd3, 2'd2, 25'h0EABCDE, 1'b0, 1'b1, 16'h005A, 3'b111, 4'hF, 16'h0, 4'b1000, 3'd5, 23'h2ABCDE, 16'h005A, 1'b0, 16'h0, 1'b0, 1'b0},
    // R3 16-bit read in 8-bit window, big-endian set, data unchanged
    '{4'd3, 2'd2, 25'h0400003, 1'b1, 1'b0, 16'h0, 3'b111, 4'hF, 16'hA1B2, 4'b0010, 3'd5, 23'h3, 16'h0, 1'b1, 16'hA1B2, 1'b0, 1'b0},
    // R4 byte lane flip in window 0
    '{4'd4, 2'd0, 25'h125, 1'b0, 1'b0, 16'h0, 3'b010, 4'hF, 16'h00CD, 4'b0010, 3'd0, 23'h24, 16'h0, 1'b1, 16'h00CD, 1'b0, 1'b0},
    // R5 16-bit write swap in window 1
    '{4'd5, 2'd1, 25'h0800010, 1'b1, 1'b1, 16'hA1B2, 3'b100, 4'hF, 16'h0, 4'b0010, 3'd4, 23'h10, 16'hB2A1, 1'b0, 16'h0, 1'b0, 1'b0},
    // R5 16-bit read swap in window 0
    '{4'd5, 2'd0, 25'h0A4, 1'b1, 1'b0, 16'h0, 3'b010, 4'hF, 16'h1357, 4'b0001, 3'd2, 23'h24, 16'h0, 1'b1, 16'h5713, 1'b0, 1'b0},
    // R4 byte lane flip in window 1
    '{4'd4, 2'd1, 25'h1800003, 1'b0, 1'b0, 16'h0, 3'b100, 4'hF, 16'h0044, 4'b1000, 3'd4, 23'h2, 16'h0, 1'b1, 16'h0044, 1'b0, 1'b0},
    // R6 bits 0 and 1 set do not affect window 1
    '{4'd6, 2'd1, 25'h0000003, 1'b0, 1'b0, 16'h0, 3'b011, 4'hF, 16'h0055, 4'b0001, 3'd4, 23'h3, 16'h0, 1'b1, 16'h0055, 1'b0, 1'b0},
    // R7 read of empty slot 2
    '{4'd7, 2'd0, 25'h280, 1'b0, 1'b0, 16'h0, 3'b000, 4'b1011, 16'h9999, 4'b0000, 3'd0, 23'h0, 16'h0, 1'b1, 16'h0, 1'b0, 1'b0},
    // R7 write to empty slot 3
    '{4'd7, 2'd2, 25'h0C00001, 1'b0, 1'b1, 16'h00EE, 3'b000, 4'b0111, 16'h0, 4'b0000, 3'd0, 23'h0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0},
    // R8 window id 3 is never routed
    '{4'd8, 2'd3, 25'h0, 1'b0, 1'b0, 16'h0, 3'b000, 4'hF, 16'h3333, 4'b0000, 3'd0, 23'h0, 16'h0, 1'b1, 16'h0, 1'b0, 1'b0},
    // R9 acknowledge after lane flip (0xC1 -> 0xC0)
    '{4'd9, 2'd0, 25'h0C1, 1'b0, 1'b0, 16'h0, 3'b010, 4'hF, 16'h0066, 4'b0001, 3'd3, 23'h0, 16'h0, 1'b1, 16'h0066, 1'b1, 1'b0},
    // R9 no acknowledge for empty slot
    '{4'd9, 2'd0, 25'h0C0, 1'b0, 1'b0, 16'h0, 3'b000, 4'b1110, 16'h0077, 4'b0000, 3'd0, 23'h0, 16'h0, 1'b1, 16'h0, 1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cfgWr(input logic [7:0] a, input logic [7:0] d);
    cfgAddr = a; cfgWdata = d; cfgWrite = 1'b1;
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  task automatic cfgChk(input logic [7:0] a, input logic [7:0] exp, input string req);
    cfgAddr = a;
    #1;
    check(cfgRdata == exp, req, "cfg read", 32'(cfgRdata), 32'(exp));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(dnStrobe == 4'd0, "R10", "dnStrobe", 32'(dnStrobe), 0);
    check(!rspValid, "R10", "rspValid", 32'(rspValid), 0);
    check(!ackPulse, "R10", "ackPulse", 32'(ackPulse), 0);
    check(!regBigEndian, "R10", "regBigEndian", 32'(regBigEndian), 0);
    cfgChk(8'h2B, 8'h00, "R10");
    cfgChk(8'h2F, 8'h00, "R10");
    cfgChk(8'h33, 8'h00, "R10");

    // R6 configuration bytes
    cfgWr(8'h2F, 8'hFF);
    cfgChk(8'h2F, 8'h01, "R6");
    cfgChk(8'h2B, 8'h00, "R6");
    check(!regBigEndian, "R6", "regBigEndian after 0x2F write", 32'(regBigEndian), 0);
    cfgWr(8'h2B, 8'h01);
    check(regBigEndian, "R6", "regBigEndian after 0x2B write", 32'(regBigEndian), 1);
    cfgWr(8'h2C, 8'hFF);
    cfgChk(8'h2C, 8'h00, "R6");
    cfgChk(8'h2B, 8'h01, "R6");
    cfgChk(8'h33, 8'h00, "R6");
    cfgWr(8'h2B, 8'hFE);
    check(!regBigEndian, "R6", "regBigEndian after clear", 32'(regBigEndian), 0);
    cfgWr(8'h2F, 8'h00);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string rs;
      int expSlot;
      v = VECS[i];
      rs = $sformatf("R%0d", v.rq);
      cfgWr(8'h2B, {7'd0, v.be[0]});
      cfgWr(8'h2F, {7'd0, v.be[1]});
      cfgWr(8'h33, {7'd0, v.be[2]});
      slotPresent = v.present;
      dnRdata = v.mrd;
      reqWin = v.win; reqAddr = v.addr; reqSize16 = v.sz16;
      reqWrite = v.wr; reqWdata = v.wdata; reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
      expSlot = 0;
      for (int s = 0; s < 4; s++) if (v.expStb[s]) expSlot = s;
      check(dnStrobe == v.expStb, rs, $sformatf("vec %0d dnStrobe", i), 32'(dnStrobe), 32'(v.expStb));
      if (v.expStb != 4'd0) begin
        check(dnSpace == v.expSp, rs, $sformatf("vec %0d dnSpace", i), 32'(dnSpace), 32'(v.expSp));
        check(dnOffset == v.expOff, rs, $sformatf("vec %0d dnOffset", i), 32'(dnOffset), 32'(v.expOff));
        check(dnWrite == v.wr, rs, $sformatf("vec %0d dnWrite", i), 32'(dnWrite), 32'(v.wr));
        if (v.wr)
          check(dnWdata == v.expWd, rs, $sformatf("vec %0d dnWdata", i), 32'(dnWdata), 32'(v.expWd));
      end
      check(ackPulse == v.expAck, rs, $sformatf("vec %0d ackPulse", i), 32'(ackPulse), 32'(v.expAck));
      if (v.expAck) begin
        check(ackSlot == 2'(expSlot), rs, $sformatf("vec %0d ackSlot", i), 32'(ackSlot), 32'(expSlot));
        check(ackLine == v.expAckLine, rs, $sformatf("vec %0d ackLine", i), 32'(ackLine), 32'(v.expAckLine));
      end
      @(negedge clk);
      // R8 strobe lasts one cycle, response two cycles after the request
      check(dnStrobe == 4'd0, "R8", $sformatf("vec %0d strobe width", i), 32'(dnStrobe), 0);
      check(rspValid == v.expRspV, rs, $sformatf("vec %0d rspValid", i), 32'(rspValid), 32'(v.expRspV));
      if (v.expRspV)
        check(rspData == v.expRsp, rs, $sformatf("vec %0d rspData", i), 32'(rspData), 32'(v.expRsp));
      @(negedge clk);
      check(!rspValid, "R8", $sformatf("vec %0d rsp width", i), 32'(rspValid), 0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule